// File: doc/BRIEF.md
# Two-Pass 2D-FFT Stream Exerciser

This block exercises a two-dimensional FFT datapath built from two external one-dimensional FFT engines, one working along rows and one along columns. After a start pulse it streams an impulse matrix into the row engine and compares every returned sample with the closed-form row response. It then builds the transposed intermediate matrix on its own, without any transpose memory, streams it into the column engine, and compares that engine's output with its closed-form response.

A host watches two results: a single mismatch counter shared by both passes, and a completion flag. Every stream uses AXI4-Stream valid/ready handshakes, so any FFT implementation with that interface can be attached unchanged. A sample is one 32-bit beat with the real part in bits 15:0 and the imaginary part in bits 31:16.

Top module: `fft2d_stream_tester`

## Requirements
- R1: While reset is held and after its release until start, no stream carries a valid beat, no stream is ready, done is low and err_count is zero.
- R2: A start pulse while idle or done begins the row pass, which sends ROWS lines of COLS beats; only the first beat of line 0 is nonzero, and it holds IMP_RE in bits 15:0 and zero in bits 31:16.
- R3: In the row pass each returned sample is expected to equal IMP_RE (imaginary zero) in line 0 and zero in all other lines; each mismatching beat adds one to err_count.
- R4: The column pass starts only after every row-pass beat has been sent and every row-engine output beat has been checked; no column-stream beat is valid before that.
- R5: The column pass sends COLS lines of ROWS beats in which the first beat of every line equals IMP_RE and all other beats are zero.
- R6: In the column pass every returned sample is expected to equal IMP_RE (imaginary zero); each mismatching beat adds one to err_count.
- R7: TLAST is driven high exactly on the last beat of each sent line; a returned beat whose TLAST differs from the end-of-line position adds one to err_count, independently of its data check.
- R8: While a sent beat is valid and not accepted, its TVALID, TDATA and TLAST stay unchanged.
- R9: done rises once all column output has been checked; a start during a pass has no effect, and a start after done clears err_count and reruns both passes.
- R10: A beat counts only when TVALID and TREADY are both high; gaps and backpressure on any stream neither drop nor repeat samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a two-pass run |
| m_row_tvalid | output | 1 | Row-engine input valid |
| m_row_tready | input | 1 | Row-engine input ready |
| m_row_tdata | output | 32 | Row-engine input sample |
| m_row_tlast | output | 1 | Last beat of a row |
| s_row_tvalid | input | 1 | Row-engine output valid |
| s_row_tready | output | 1 | Row-engine output ready |
| s_row_tdata | input | 32 | Row-engine output sample |
| s_row_tlast | input | 1 | Row-engine output end of line |
| m_col_tvalid | output | 1 | Column-engine input valid |
| m_col_tready | input | 1 | Column-engine input ready |
| m_col_tdata | output | 32 | Column-engine input sample |
| m_col_tlast | output | 1 | Last beat of a line |
| s_col_tvalid | input | 1 | Column-engine output valid |
| s_col_tready | output | 1 | Column-engine output ready |
| s_col_tdata | input | 32 | Column-engine output sample |
| s_col_tlast | input | 1 | Column-engine output end of line |
| err_count | output | 32 | Mismatches over both passes |
| done | output | 1 | Both passes fully checked |

## Verification
A wrong line or beat index shows at once as a nonzero sample in the wrong place on a sent stream, or as a spurious mismatch within the same line on a returned one, so the bench counts every nonzero sent beat by position and checks the final count after deliberately corrupted beats. A stuck pass state shows as a missing done or as a column beat appearing before the last row beat was consumed, which the bench timestamps. A stimulus that moves while stalled is caught on the very next cycle by the engine models.

// File: rtl/fft2d_stream_tester.sv
module fft2d_stream_tester #(
  parameter int ROWS = 32,
  parameter int COLS = 64,
  parameter int EW = 32,
  parameter logic [15:0] IMP_RE = 16'h0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          m_row_tvalid,
  input  logic          m_row_tready,
  output logic [31:0]   m_row_tdata,
  output logic          m_row_tlast,
  input  logic          s_row_tvalid,
  output logic          s_row_tready,
  input  logic [31:0]   s_row_tdata,
  input  logic          s_row_tlast,
  output logic          m_col_tvalid,
  input  logic          m_col_tready,
  output logic [31:0]   m_col_tdata,
  output logic          m_col_tlast,
  input  logic          s_col_tvalid,
  output logic          s_col_tready,
  input  logic [31:0]   s_col_tdata,
  input  logic          s_col_tlast,
  output logic [EW-1:0] err_count,
  output logic          done
);
  localparam int MAXD = (ROWS > COLS) ? ROWS : COLS;
  localparam int IW = $clog2(MAXD + 1);
  localparam logic [IW-1:0] RL = IW'(ROWS - 1);
  localparam logic [IW-1:0] CL = IW'(COLS - 1);
  localparam logic [31:0] IMPV = {16'h0000, IMP_RE};

  typedef enum logic [1:0] {S_IDLE, S_ROW, S_COL, S_DONE} state_t;
  state_t state;

  logic [IW-1:0] tx_i, tx_j, rx_i, rx_j;
  logic tx_fin, rx_fin;

  wire in_row = (state == S_ROW);
  wire in_col = (state == S_COL);
  wire active = in_row | in_col;
  wire [IW-1:0] lines_last = in_col ? CL : RL;
  wire [IW-1:0] len_last = in_col ? RL : CL;

  wire tx_v = active && !tx_fin;
  wire [31:0] tx_data = (tx_j == '0 && (in_col || tx_i == '0)) ? IMPV : 32'h0;
  wire tx_last = (tx_j == len_last);

  assign m_row_tvalid = in_row && tx_v;
  assign m_col_tvalid = in_col && tx_v;
  assign m_row_tdata  = tx_data;
  assign m_col_tdata  = tx_data;
  assign m_row_tlast  = tx_last;
  assign m_col_tlast  = tx_last;

  wire rx_rdy = active && !rx_fin;
  assign s_row_tready = in_row && rx_rdy;
  assign s_col_tready = in_col && rx_rdy;

  wire tx_go = (m_row_tvalid && m_row_tready) || (m_col_tvalid && m_col_tready);
  wire rx_go = (s_row_tvalid && s_row_tready) || (s_col_tvalid && s_col_tready);
  wire [31:0] rx_d = in_col ? s_col_tdata : s_row_tdata;
  wire rx_l = in_col ? s_col_tlast : s_row_tlast;
  wire [31:0] rx_exp = (in_col || rx_i == '0) ? IMPV : 32'h0;
  wire [1:0] err_inc = {1'b0, rx_d != rx_exp} + {1'b0, rx_l != (rx_j == len_last)};

  assign done = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      tx_i <= '0; tx_j <= '0; rx_i <= '0; rx_j <= '0;
      tx_fin <= 1'b0; rx_fin <= 1'b0;
      err_count <= '0;
    end else if (start && !active) begin
      state <= S_ROW;
      tx_i <= '0; tx_j <= '0; rx_i <= '0; rx_j <= '0;
      tx_fin <= 1'b0; rx_fin <= 1'b0;
      err_count <= '0;
    end else if (active && tx_fin && rx_fin) begin
      state <= in_row ? S_COL : S_DONE;
      tx_i <= '0; tx_j <= '0; rx_i <= '0; rx_j <= '0;
      tx_fin <= 1'b0; rx_fin <= 1'b0;
    end else begin
      if (tx_go) begin
        if (tx_j == len_last) begin
          tx_j <= '0;
          if (tx_i == lines_last) tx_fin <= 1'b1;
          else tx_i <= tx_i + 1'b1;
        end else tx_j <= tx_j + 1'b1;
      end
      if (rx_go) begin
        err_count <= err_count + EW'(err_inc);
        if (rx_j == len_last) begin
          rx_j <= '0;
          if (rx_i == lines_last) rx_fin <= 1'b1;
          else rx_i <= rx_i + 1'b1;
        end else rx_j <= rx_j + 1'b1;
      end
    end
  end

  p_row_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_row_tvalid && !m_row_tready |=> m_row_tvalid && $stable(m_row_tdata) && $stable(m_row_tlast));
  p_col_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_col_tvalid && !m_col_tready |=> m_col_tvalid && $stable(m_col_tdata) && $stable(m_col_tlast));
  p_err_nodec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> err_count >= $past(err_count));
  p_err_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (err_count - $past(err_count)) <= EW'(2));
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !m_row_tvalid && !m_col_tvalid && !s_row_tready && !s_col_tready);
  p_one_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_col_tvalid |-> !m_row_tvalid && !s_row_tready);
endmodule

// File: tb/test_fft2d_stream_tester.sv
module fft_impulse_model #(
  parameter int LEN = 8,
  parameter logic [31:0] IMPV = 32'h1
) (
  input  logic        clk,
  input  logic        clr,
  input  int          stall,
  input  int          bad_beat,
  input  int          bad_kind,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_last,
  output int          n_in,
  output int          n_out,
  output int          nz_first,
  output int          nz_other,
  output int          bad_val,
  output int          last_bad,
  output int          hold_bad,
  output int          first_in_cyc,
  output int          last_out_cyc
);
  logic [31:0] q[$];
  logic lq[$];
  int pos, cyc, nq;
  logic [31:0] row0, pd;
  logic fire_out, pv, pr, pl;

  initial begin
    in_ready = 0; out_valid = 0; out_data = 0; out_last = 0;
    fire_out = 0; pv = 0; pr = 0; pd = 0; pl = 0; cyc = 0; pos = 0; nq = 0; row0 = 0;
    n_in = 0; n_out = 0; nz_first = 0; nz_other = 0; bad_val = 0; last_bad = 0; hold_bad = 0;
    first_in_cyc = 0; last_out_cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (clr) begin
        q.delete(); lq.delete();
        pos = 0; nq = 0; fire_out = 0; pv = 0; pr = 0;
        in_ready = 0; out_valid = 0;
        n_in = 0; n_out = 0; nz_first = 0; nz_other = 0; bad_val = 0; last_bad = 0; hold_bad = 0;
        first_in_cyc = 0; last_out_cyc = 0;
        continue;
      end
      if (fire_out) begin
        n_out++; last_out_cyc = cyc;
        void'(q.pop_front()); void'(lq.pop_front());
      end
      if (pv && !pr && (!in_valid || in_data != pd || in_last != pl)) hold_bad++;
      out_valid = (q.size() > 0) && (stall == 0 || (cyc % (stall + 1)) != 1);
      if (q.size() > 0) begin out_data = q[0]; out_last = lq[0]; end
      in_ready = (stall == 0) || ((cyc % stall) != 0);
      #1;
      fire_out = out_valid && out_ready;
      pv = in_valid; pr = in_ready; pd = in_data; pl = in_last;
      if (in_valid && in_ready) begin
        if (n_in == 0) first_in_cyc = cyc;
        if (in_data != 0) begin
          if (pos == 0) nz_first++; else nz_other++;
          if (in_data != IMPV) bad_val++;
        end
        if (in_last != (pos == LEN - 1)) last_bad++;
        if (pos == 0) row0 = in_data;
        n_in++;
        if (pos == LEN - 1) begin
          pos = 0;
          for (int k = 0; k < LEN; k++) begin
            logic [31:0] d;
            logic l;
            d = row0; l = (k == LEN - 1);
            if (nq == bad_beat) begin
              if (bad_kind == 1 || bad_kind == 3) d = d ^ 32'h0001_0000;
              if (bad_kind == 2 || bad_kind == 3) l = !l;
            end
            q.push_back(d); lq.push_back(l);
            nq++;
          end
        end else pos++;
      end
    end
  end
endmodule

module test_fft2d_stream_tester;
  localparam int ROWS = 4;
  localparam int COLS = 8;
  localparam logic [31:0] IMPV = 32'h0000_0001;

  logic clk = 0, rst_n = 0, start = 0, clr = 1;
  always #10 clk = ~clk;

  logic m_row_tvalid, m_row_tready, m_row_tlast, s_row_tvalid, s_row_tready, s_row_tlast;
  logic m_col_tvalid, m_col_tready, m_col_tlast, s_col_tvalid, s_col_tready, s_col_tlast;
  logic [31:0] m_row_tdata, s_row_tdata, m_col_tdata, s_col_tdata, err_count;
  logic done;
  int r_stall = 0, r_bb = -1, r_bk = 0, c_stall = 0, c_bb = -1, c_bk = 0;
  int r_nin, r_nout, r_nzf, r_nzo, r_bv, r_lb, r_hb, r_fic, r_loc;
  int c_nin, c_nout, c_nzf, c_nzo, c_bv, c_lb, c_hb, c_fic, c_loc;
  int checks = 0, fails = 0;

  fft2d_stream_tester #(.ROWS(ROWS), .COLS(COLS), .EW(32), .IMP_RE(16'h0001)) i_fft2d_stream_tester (
    .clk(clk), .rst_n(rst_n), .start(start),
    .m_row_tvalid(m_row_tvalid), .m_row_tready(m_row_tready), .m_row_tdata(m_row_tdata), .m_row_tlast(m_row_tlast),
    .s_row_tvalid(s_row_tvalid), .s_row_tready(s_row_tready), .s_row_tdata(s_row_tdata), .s_row_tlast(s_row_tlast),
    .m_col_tvalid(m_col_tvalid), .m_col_tready(m_col_tready), .m_col_tdata(m_col_tdata), .m_col_tlast(m_col_tlast),
    .s_col_tvalid(s_col_tvalid), .s_col_tready(s_col_tready), .s_col_tdata(s_col_tdata), .s_col_tlast(s_col_tlast),
    .err_count(err_count), .done(done));

  fft_impulse_model #(.LEN(COLS), .IMPV(IMPV)) i_row_model (
    .clk(clk), .clr(clr), .stall(r_stall), .bad_beat(r_bb), .bad_kind(r_bk),
    .in_valid(m_row_tvalid), .in_ready(m_row_tready), .in_data(m_row_tdata), .in_last(m_row_tlast),
    .out_valid(s_row_tvalid), .out_ready(s_row_tready), .out_data(s_row_tdata), .out_last(s_row_tlast),
    .n_in(r_nin), .n_out(r_nout), .nz_first(r_nzf), .nz_other(r_nzo), .bad_val(r_bv),
    .last_bad(r_lb), .hold_bad(r_hb), .first_in_cyc(r_fic), .last_out_cyc(r_loc));

  fft_impulse_model #(.LEN(ROWS), .IMPV(IMPV)) i_col_model (
    .clk(clk), .clr(clr), .stall(c_stall), .bad_beat(c_bb), .bad_kind(c_bk),
    .in_valid(m_col_tvalid), .in_ready(m_col_tready), .in_data(m_col_tdata), .in_last(m_col_tlast),
    .out_valid(s_col_tvalid), .out_ready(s_col_tready), .out_data(s_col_tdata), .out_last(s_col_tlast),
    .n_in(c_nin), .n_out(c_nout), .nz_first(c_nzf), .nz_other(c_nzo), .bad_val(c_bv),
    .last_bad(c_lb), .hold_bad(c_hb), .first_in_cyc(c_fic), .last_out_cyc(c_loc));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input int st, input int rbb, input int rbk, input int cbb, input int cbk,
                     input bit mid_start, input int exp_err, input string name);
    int n;
    clr = 1; r_stall = st; c_stall = st; r_bb = rbb; r_bk = rbk; c_bb = cbb; c_bk = cbk;
    repeat (2) @(negedge clk);
    clr = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      if (mid_start && n == 10) start = 1;
      else start = 0;
    end
    start = 0;
    @(negedge clk);
    chk({"R9 done ", name}, done, 1);
    chk({"R3 R6 R7 err_count ", name}, err_count, exp_err);
    chk({"R2 row beats sent ", name}, r_nin, ROWS * COLS);
    chk({"R2 row impulse position ", name}, r_nzf * 1000 + r_nzo, 1000);
    chk({"R2 R5 impulse value ", name}, r_bv + c_bv, 0);
    chk({"R7 sent tlast ", name}, r_lb + c_lb, 0);
    chk({"R5 col beats sent ", name}, c_nin, ROWS * COLS);
    chk({"R5 col impulse positions ", name}, c_nzf * 1000 + c_nzo, COLS * 1000);
    chk({"R4 col after row ", name}, (c_fic > r_loc) ? 1 : 0, 1);
    chk({"R10 all outputs consumed ", name}, r_nout + c_nout, 2 * ROWS * COLS);
    chk({"R8 stall hold ", name}, r_hb + c_hb, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {m_row_tvalid, m_col_tvalid}, 0);
    chk("R1 reset ready", {s_row_tready, s_col_tready}, 0);
    chk("R1 reset done/err", {done, err_count}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {m_row_tvalid, m_col_tvalid, s_row_tready, s_col_tready, done}, 0);
    chk("R1 idle err", err_count, 0);
    run(0, -1, 0, -1, 0, 0, 0, "clean");
    run(3, -1, 0, -1, 0, 0, 0, "stalled");
    run(2, 3, 1, -1, 0, 0, 1, "R3 row0 data");
    run(0, 12, 1, -1, 0, 0, 1, "R3 zero-row data");
    run(4, -1, 0, 20, 1, 0, 1, "R6 col data");
    run(0, 7, 2, -1, 0, 0, 1, "R7 missing tlast");
    run(3, -1, 0, 1, 2, 0, 1, "R7 early tlast");
    run(0, -1, 0, 3, 3, 0, 2, "R7 data and tlast");
    run(2, -1, 0, -1, 0, 1, 0, "R9 start while busy");
    run(0, -1, 0, -1, 0, 0, 0, "R9 rerun clears");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule